// File: doc/BRIEF.md
# Unresolved-Branch Speculation Limiter

This block keeps a running tally of branches that have been decoded but not yet resolved. A thermal management controller uses it to throttle speculation. While the thermal response is engaged, decode is held whenever the tally rises above a ceiling that software programs. When the tally falls back to the ceiling or below, decode is released. When the response is not engaged, the ceiling has no effect and the tally is only tracked.

Each cycle the decode stage reports how many branches it decoded, and the execution back end reports how many branches resolved. The tally moves by the difference between the two. A pipeline flush replaces the tally with the number of branches that survive the flush, which is given on an input; the value is zero when nothing survives. The tally saturates at its top value. An attempt to go below zero clamps the tally at zero and sets a sticky error flag.

Top module: `spec_throttle_limiter`

## Requirements
- R1: While reset is asserted and after it is released, the tally is 0, the stall output is low and the error flag is low.
- R2: On a clock edge without flush, the tally becomes its previous value plus the decoded count minus the resolved count. The new value is visible after that edge.
- R3: A decoded or resolved count above 4 is treated as 4.
- R4: The tally saturates at 2^CNT_W-1 (63 by default) and never wraps to a small value.
- R5: If the resolved count would take the tally below zero, the tally becomes 0 and the error flag is set after that edge.
- R6: Once set, the error flag stays set until reset. A flush does not clear it.
- R7: On a clock edge with flush high, the tally is loaded from the surviving-count input. The decoded and resolved counts of that cycle are ignored.
- R8: With the response enabled, the stall output is high in exactly those cycles where the registered tally is strictly greater than the limit input.
- R9: With the response disabled, the stall output is low whatever the tally and the limit are.
- R10: A new limit value changes the stall output in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_decoded | input | 3 | Branches decoded this cycle (0..4) |
| br_resolved | input | 3 | Branches resolved this cycle (0..4) |
| flush | input | 1 | Pipeline flush |
| flush_keep | input | CNT_W | Branches surviving the flush |
| throttle_en | input | 1 | Thermal response engaged |
| spec_limit | input | CNT_W | Programmed ceiling on unresolved branches |
| decode_stall | output | 1 | Hold the decode stage |
| inflight | output | CNT_W | Current unresolved-branch tally |
| underflow_err | output | 1 | Sticky underflow indicator |

## Verification
The embedded properties check these on every cycle: the flush load, the tally holding when there is no traffic, the ceiling holding under pressure, the error flag staying set, the flag being raised on an underflow attempt, and the stall output staying low without the response. Only the bench scenarios show the exact net arithmetic under mixed traffic, including clamping of out-of-range counts. The same goes for the exact stall comparison at the boundary where the tally equals the limit, and for the immediate effect of a limit change. A reference model in the bench follows random traffic and directed corner cases such as long decode bursts, drains below zero, and a flush after an error.

// File: rtl/spec_lim_pkg.sv
package spec_lim_pkg;
  localparam int unsigned PER_CYC_MAX = 4;
  localparam int unsigned RATE_W = $clog2(PER_CYC_MAX + 1);
  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/lim_clamp.sv
module lim_clamp
  import spec_lim_pkg::*;
#(
  parameter int unsigned LIMIT = PER_CYC_MAX
) (
  input  rate_t raw,
  output rate_t clamped
);
  localparam rate_t TOP = rate_t'(LIMIT);

  always_comb begin
    clamped = (raw > TOP) ? TOP : raw;
  end
endmodule

// File: rtl/lim_counter.sv
module lim_counter
  import spec_lim_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rate_t            inc,
  input  rate_t            dec,
  input  logic             flush,
  input  logic [CNT_W-1:0] keep,
  output logic [CNT_W-1:0] cnt_q,
  output logic             err_q
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_d;
  logic             err_d;
  logic             cnt_en;
  int               sum_i;

  always_comb begin
    sum_i  = int'(cnt_q) + int'(inc) - int'(dec);
    cnt_d  = cnt_q;
    err_d  = err_q;
    cnt_en = 1'b0;
    if (flush) begin
      cnt_d  = keep;
      cnt_en = 1'b1;
    end else if (inc != '0 || dec != '0) begin
      cnt_en = 1'b1;
      if (sum_i < 0) begin
        cnt_d = '0;
        err_d = 1'b1;
      end else if (sum_i > CNT_MAX) begin
        cnt_d = CNT_W'(CNT_MAX);
      end else begin
        cnt_d = CNT_W'(sum_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assert_flush_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == $past(keep));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && inc == '0 && dec == '0) |=> $stable(cnt_q));
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && cnt_q == CNT_W'(CNT_MAX) && inc >= dec) |=> cnt_q == CNT_W'(CNT_MAX));
  assert_underflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && int'(dec) > int'(cnt_q) + int'(inc)) |=> (err_q && cnt_q == '0));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/lim_stall.sv
module lim_stall #(
  parameter int unsigned CNT_W = 6
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] limit,
  input  logic             en,
  output logic             stall
);
  logic over;

  always_comb begin
    over  = (cnt > limit);
    stall = en & over;
  end

  always_comb begin
    if (!en) assert_off_no_stall_R9: assert (!stall);
  end
endmodule

// File: rtl/spec_throttle_limiter.sv
module spec_throttle_limiter
  import spec_lim_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       br_decoded,
  input  logic [2:0]       br_resolved,
  input  logic             flush,
  input  logic [CNT_W-1:0] flush_keep,
  input  logic             throttle_en,
  input  logic [CNT_W-1:0] spec_limit,
  output logic             decode_stall,
  output logic [CNT_W-1:0] inflight,
  output logic             underflow_err
);
  rate_t inc_c;
  rate_t dec_c;

  lim_clamp #(.LIMIT(PER_CYC_MAX)) u_clamp_dec (
    .raw(rate_t'(br_decoded)), .clamped(inc_c));
  lim_clamp #(.LIMIT(PER_CYC_MAX)) u_clamp_res (
    .raw(rate_t'(br_resolved)), .clamped(dec_c));

  lim_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .inc(inc_c), .dec(dec_c),
    .flush(flush), .keep(flush_keep), .cnt_q(inflight), .err_q(underflow_err));

  lim_stall #(.CNT_W(CNT_W)) u_stall (
    .cnt(inflight), .limit(spec_limit), .en(throttle_en), .stall(decode_stall));

  assert_stall_needs_excess_R8: assert property (@(posedge clk) disable iff (!rst_n)
    decode_stall |-> (throttle_en && inflight > spec_limit));
endmodule

// File: tb/spec_throttle_limiter_tb.sv
module spec_throttle_limiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] br_decoded = '0;
  logic [2:0] br_resolved = '0;
  logic flush = 1'b0;
  logic [CNT_W-1:0] flush_keep = '0;
  logic throttle_en = 1'b0;
  logic [CNT_W-1:0] spec_limit = '0;
  logic decode_stall;
  logic [CNT_W-1:0] inflight;
  logic underflow_err;

  int checks = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_throttle_limiter #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_decoded(br_decoded), .br_resolved(br_resolved),
    .flush(flush), .flush_keep(flush_keep), .throttle_en(throttle_en),
    .spec_limit(spec_limit), .decode_stall(decode_stall), .inflight(inflight),
    .underflow_err(underflow_err));

  function automatic int clip4(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  function automatic bit exp_stall(input int c, input bit en, input int lim);
    return en && (c > lim);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int d, input int r, input bit f, input int keep,
                      input bit en, input int lim, input string tag);
    int s;
    @(negedge clk);
    br_decoded = 3'(d); br_resolved = 3'(r); flush = f;
    flush_keep = CNT_W'(keep); throttle_en = en; spec_limit = CNT_W'(lim);
    #1;
    chk({tag, " stall R8/R9/R10"}, int'(decode_stall), int'(exp_stall(m_cnt, en, lim)));
    @(posedge clk);
    if (f) m_cnt = keep;
    else begin
      s = m_cnt + clip4(d) - clip4(r);
      if (s < 0) begin m_cnt = 0; m_err = 1'b1; end
      else if (s > CMAX) m_cnt = CMAX;
      else m_cnt = s;
    end
    #1;
    chk({tag, " count R2"}, int'(inflight), m_cnt);
    chk({tag, " err R5/R6"}, int'(underflow_err), int'(m_err));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1d5;
    void'($urandom(seed));
    #(CLK_PERIOD * 2 + 1);
    chk("reset count R1", int'(inflight), 0);
    chk("reset stall R1", int'(decode_stall), 0);
    chk("reset err R1", int'(underflow_err), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("post-reset count R1", int'(inflight), 0);

    step(1, 0, 0, 0, 1, 1, "one branch");
    step(1, 0, 0, 0, 1, 1, "two branches R8");
    chk("over limit stall R8", int'(decode_stall), 1);
    step(0, 0, 0, 0, 1, 2, "limit raised R10");
    chk("equal limit no stall R8", int'(decode_stall), 0);
    step(0, 0, 0, 0, 1, 0, "limit lowered R10");
    step(2, 1, 0, 0, 1, 1, "net add R2");
    step(7, 6, 0, 0, 1, 1, "clamped counts R3");
    chk("clamp net zero R3", int'(inflight), 3);
    for (int i = 0; i < 20; i++) step(4, 0, 0, 0, 1, 5, "burst R4");
    chk("saturate R4", int'(inflight), CMAX);
    step(0, 0, 0, 0, 0, 0, "disabled R9");
    chk("disabled no stall R9", int'(decode_stall), 0);
    step(0, 0, 1, 2, 0, 0, "flush keep R7");
    step(4, 0, 1, 0, 0, 0, "flush ignores traffic R7");
    chk("flush to zero R7", int'(inflight), 0);
    step(1, 3, 0, 0, 0, 0, "underflow R5");
    chk("underflow clamp R5", int'(inflight), 0);
    chk("underflow flag R5", int'(underflow_err), 1);
    step(0, 0, 1, 5, 1, 1, "flush after err R6");
    chk("err sticky R6", int'(underflow_err), 1);

    for (int i = 0; i < 3000; i++) begin
      int d, r;
      d = int'($urandom_range(0, 6));
      r = (m_cnt > 8) ? int'($urandom_range(0, 6)) : int'($urandom_range(0, 3));
      step(d, r, ($urandom_range(0, 40) == 0), int'($urandom_range(0, 10)),
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 12)), "random R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule